// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller with Selectable Trigger Mode

This block gathers eight interrupt request lines and presents one interrupt signal to a processor. Each line is captured in a request register. Lines not blocked by the mask compete under fixed priority, with line 0 the highest. When the processor acknowledges, the block hands back an 8-bit vector and marks the line as in service. Each line is either edge-sensitive or level-sensitive. Level sensitivity comes from a single chip-wide bit, which is loaded every time the first initialization word is written, or from that line's bit in an 8-bit per-line trigger-select register. Either source makes the line level-sensitive.

Software reaches the block through a register write port and a register read port. Address 0 takes commands: the first initialization word, end-of-interrupt, and the read-select and poll command. Address 1 takes the initialization data words while initialization is in progress and the mask at all other times. Address 2 holds the trigger-select register.

A small sequencer steps through the initialization words. It has four states. ST_READY is the normal state. ST_BASE waits for the vector base. ST_CASC waits for the cascade word, which is accepted and discarded. ST_FOURTH waits for the fourth word, which is accepted and discarded.
- Writing the first initialization word moves the sequencer from any state to ST_BASE.
- From ST_BASE, a data write goes to ST_CASC when cascade mode was selected. Otherwise it goes to ST_FOURTH when a fourth word was announced. Otherwise it returns to ST_READY.
- From ST_CASC, a data write goes to ST_FOURTH when a fourth word was announced, and to ST_READY otherwise.
- From ST_FOURTH, a data write returns to ST_READY.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset, the request register, in-service register, mask, trigger-select register, chip-wide level bit and vector base are all zero, the poll flag is clear, and `int_out` is low.
- R2: A line is level-sensitive when the chip-wide level bit is 1 or when its trigger-select bit is 1. Otherwise the line is edge-sensitive.
- R3: An edge-sensitive line sets its request bit on the clock edge that first sees the input high after a low sample. The bit stays set after the input falls, until the line is acknowledged or the first initialization word is written.
- R4: A level-sensitive line's request bit equals the input level sampled on the previous clock edge.
- R5: A command write (address 0) with bit 4 set is the first initialization word. It works as follows:
  - Bit 3 loads the chip-wide level bit. Bit 1 = 1 selects single mode. Bit 0 = 1 announces a fourth word.
  - The write clears the mask, the in-service register, the poll flag and the edge-sensitive request bits, and sets the read select to the request register.
  - The write starts the sequence in which the next address-1 write supplies the vector base in bits 7:3. A cascade word follows if bit 1 was 0, and a fourth word follows if bit 0 was 1.
  - After the sequence, address-1 writes load the mask.
- R6: Priority is fixed, with line 0 highest. `int_out` is high exactly when some unmasked request exists and its highest-priority line outranks every in-service line, or no line is in service.
- R7: On `ack` with `int_out` high, `ack_vec` = {base, winning line number}. The winning line's in-service bit is set. Its request bit is cleared only if the line is edge-sensitive. With `int_out` low, `ack_vec` = {base, 3'b111} and no state changes.
- R8: A command write with bits 4 and 3 both 0 and bits 7:5 = 3'b001 clears the highest-priority set in-service bit.
- R9: A command write with bit 4 = 0 and bit 3 = 1 is a read-select and poll command. Bit 2 = 1 sets the poll flag. When bit 1 = 1, bit 0 chooses what an address-0 read returns: 0 returns the request register and 1 returns the in-service register.
- R10: While the poll flag is set, an address-0 read with `rd_en` returns {`int_out`, 4'b0000, winning line number, or 0 when `int_out` is low}. It acts as an acknowledge and clears the poll flag.
- R11: The trigger-select register is written and read at address 2, 8 bits wide. Address-1 reads return the mask.
- R12: A masked line still records its request bit but does not raise `int_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Interrupt request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 command, 1 data/mask, 2 trigger select) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (has an effect only for a poll read) |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| ack | input | 1 | Interrupt acknowledge strobe |
| ack_vec | output | 8 | Vector for the current acknowledge |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The checker watches five behaviours on every cycle:
- level-sensitive request bits track the previous input level;
- `int_out` stays low when every request is masked;
- an acknowledge always sets the granted in-service bit;
- an end-of-interrupt removes exactly one in-service bit;
- the chip-wide level bit always follows bit 3 of the last first initialization word.

Other behaviours can only be shown by the bench's scenarios:
- the initialization sequence routing the data writes to the base, cascade, fourth word and mask;
- edge request bits being held and cleared;
- the winner in every pair of lines;
- priority nesting against an in-service line;
- spurious acknowledge;
- the poll word.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_BASE   = 2'd1,
        ST_CASC   = 2'd2,
        ST_FOURTH = 2'd3
    } init_state_e;

    localparam logic [1:0] ADR_CMD  = 2'd0;
    localparam logic [1:0] ADR_DATA = 2'd1;
    localparam logic [1:0] ADR_TRIG = 2'd2;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] irq_in,
    input  logic [W-1:0] lvl_eff,
    input  logic         clr_edge,
    input  logic [W-1:0] ack_clr,
    output logic [W-1:0] irr
);
    logic [W-1:0] prev_q;

    for (genvar g = 0; g < W; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b0;
                irr[g]    <= 1'b0;
            end else begin
                prev_q[g] <= irq_in[g];
                if (lvl_eff[g])
                    irr[g] <= irq_in[g];
                else if (irq_in[g] && !prev_q[g])
                    irr[g] <= 1'b1;
                else if (ack_clr[g] || clr_edge)
                    irr[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_init_fsm.sv
module irq_init_fsm
    import irq_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic icw1_wr,
    input  logic cfg_single,
    input  logic cfg_four,
    input  logic data_wr,
    output logic base_ld,
    output logic mask_ld
);
    init_state_e state_q, state_d;
    logic single_q, four_q;

    always_comb begin
        state_d = state_q;
        if (icw1_wr) begin
            state_d = ST_BASE;
        end else if (data_wr) begin
            unique case (state_q)
                ST_READY:  state_d = ST_READY;
                ST_BASE:   state_d = !single_q ? ST_CASC : (four_q ? ST_FOURTH : ST_READY);
                ST_CASC:   state_d = four_q ? ST_FOURTH : ST_READY;
                ST_FOURTH: state_d = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_READY;
            single_q <= 1'b1;
            four_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (icw1_wr) begin
                single_q <= cfg_single;
                four_q   <= cfg_four;
            end
        end
    end

    always_comb begin
        base_ld = 1'b0;
        mask_ld = 1'b0;
        unique case (state_q)
            ST_READY:  mask_ld = data_wr && !icw1_wr;
            ST_BASE:   base_ld = data_wr && !icw1_wr;
            ST_CASC:   ;
            ST_FOURTH: ;
        endcase
    end
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
    import irq_ctrl_pkg::*;
#(
    parameter int N_IN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] irq_in,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic            rd_en,
    input  logic [1:0]      rd_addr,
    output logic [7:0]      rd_data,
    input  logic            ack,
    output logic [7:0]      ack_vec,
    output logic            int_out
);
    localparam int IW     = $clog2(N_IN);
    localparam int BASE_W = 8 - IW;

    logic [N_IN-1:0]   irr, isr_q, mask_q, trig_q, lvl_eff, pend, ack_clr;
    logic [BASE_W-1:0] base_q;
    logic              lvl_all_q, poll_q, rsel_isr_q;
    logic              pend_found, isr_found, ack_take, poll_rd;
    logic [IW-1:0]     pend_idx, isr_idx;
    logic              cmd_wr, icw1_wr, ocw3_wr, eoi_wr, data_wr, trig_wr;
    logic              base_ld, mask_ld;

    assign cmd_wr  = wr_en && (wr_addr == ADR_CMD);
    assign icw1_wr = cmd_wr && wr_data[4];
    assign ocw3_wr = cmd_wr && !wr_data[4] && wr_data[3];
    assign eoi_wr  = cmd_wr && !wr_data[4] && !wr_data[3] && (wr_data[7:5] == 3'b001);
    assign data_wr = wr_en && (wr_addr == ADR_DATA);
    assign trig_wr = wr_en && (wr_addr == ADR_TRIG);

    assign lvl_eff = trig_q | {N_IN{lvl_all_q}};
    assign pend    = irr & ~mask_q;

    irq_prio_enc #(.W(N_IN), .IW(IW)) u_pend_enc (
        .vec(pend), .found(pend_found), .idx(pend_idx));
    irq_prio_enc #(.W(N_IN), .IW(IW)) u_isr_enc (
        .vec(isr_q), .found(isr_found), .idx(isr_idx));

    assign int_out  = pend_found && (!isr_found || (pend_idx < isr_idx));
    assign poll_rd  = rd_en && (rd_addr == ADR_CMD) && poll_q;
    assign ack_take = (ack || poll_rd) && int_out && !icw1_wr;
    assign ack_clr  = ack_take ? (N_IN'(1) << pend_idx) & ~lvl_eff : '0;
    assign ack_vec  = int_out ? {base_q, pend_idx} : {base_q, {IW{1'b1}}};

    irq_req_bank #(.W(N_IN)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_eff(lvl_eff),
        .clr_edge(icw1_wr), .ack_clr(ack_clr), .irr(irr));

    irq_init_fsm u_init (
        .clk(clk), .rst_n(rst_n), .icw1_wr(icw1_wr),
        .cfg_single(wr_data[1]), .cfg_four(wr_data[0]),
        .data_wr(data_wr), .base_ld(base_ld), .mask_ld(mask_ld));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q      <= '0;
            mask_q     <= '0;
            trig_q     <= '0;
            base_q     <= '0;
            lvl_all_q  <= 1'b0;
            poll_q     <= 1'b0;
            rsel_isr_q <= 1'b0;
        end else begin
            if (trig_wr) trig_q <= wr_data[N_IN-1:0];
            if (base_ld) base_q <= wr_data[7:IW];
            if (icw1_wr) begin
                lvl_all_q  <= wr_data[3];
                isr_q      <= '0;
                mask_q     <= '0;
                poll_q     <= 1'b0;
                rsel_isr_q <= 1'b0;
            end else begin
                if (mask_ld) mask_q <= wr_data[N_IN-1:0];
                if (ocw3_wr) begin
                    poll_q <= wr_data[2];
                    if (wr_data[1]) rsel_isr_q <= wr_data[0];
                end else if (poll_rd) begin
                    poll_q <= 1'b0;
                end
                isr_q <= (isr_q & ~((eoi_wr && isr_found) ? (N_IN'(1) << isr_idx) : '0))
                       | (ack_take ? (N_IN'(1) << pend_idx) : '0);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_CMD: begin
                if (poll_q) begin
                    rd_data[7] = int_out;
                    if (int_out) rd_data[IW-1:0] = pend_idx;
                end else begin
                    rd_data = rsel_isr_q ? 8'(isr_q) : 8'(irr);
                end
            end
            ADR_DATA: rd_data = 8'(mask_q);
            ADR_TRIG: rd_data = 8'(trig_q);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int N_IN = 8,
    parameter int IW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] irq_in,
    input logic [N_IN-1:0] irr,
    input logic [N_IN-1:0] isr_q,
    input logic [N_IN-1:0] mask_q,
    input logic [N_IN-1:0] lvl_eff,
    input logic            lvl_all_q,
    input logic            int_out,
    input logic            ack_take,
    input logic            eoi_wr,
    input logic            icw1_wr,
    input logic [7:0]      wr_data,
    input logic [IW-1:0]   pend_idx
);
    // R4: level lines mirror the previous input sample
    a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irr & $past(lvl_eff)) == ($past(irq_in) & $past(lvl_eff))));

    // R6 / R12: nothing unmasked pending means no interrupt
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr & ~mask_q) == '0) |-> !int_out);

    // R7: a granted acknowledge marks its line in service
    a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> isr_q[$past(pend_idx)]);

    // R8: end-of-interrupt removes exactly one in-service bit
    a_r8_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !ack_take && (isr_q != '0)) |=>
            ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // R5: chip-wide level bit loads from bit 3 of the first word
    a_r5_level_bit: assert property (@(posedge clk) disable iff (!rst_n)
        icw1_wr |=> (lvl_all_q == $past(wr_data[3])));
endmodule

bind irq_ctrl_core irq_ctrl_chk #(.N_IN(N_IN), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irr(irr), .isr_q(isr_q),
    .mask_q(mask_q), .lvl_eff(lvl_eff), .lvl_all_q(lvl_all_q),
    .int_out(int_out), .ack_take(ack_take), .eoi_wr(eoi_wr),
    .icw1_wr(icw1_wr), .wr_data(wr_data), .pend_idx(pend_idx));

// File: tb/sim_irq_ctrl_core.sv
module sim_irq_ctrl_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ack = 1'b0;
    logic [7:0] ack_vec;
    logic       int_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_ctrl_core u0 (.*);

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic poll_rd(output logic [7:0] v);
        @(negedge clk);
        rd_addr = 2'd0; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic do_ack(output logic [7:0] v);
        @(negedge clk);
        v = ack_vec; ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic init_std();
        wr(2'd0, 8'h13);   // single, fourth word follows
        wr(2'd1, 8'h40);   // base
        wr(2'd1, 8'h01);   // fourth word
    endtask

    task automatic rd_isr(output logic [7:0] v);
        wr(2'd0, 8'h0B);
        rd(2'd0, v);
        wr(2'd0, 8'h0A);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 irr", v, 8'h00);
        rd(2'd1, v); chk("R1 mask", v, 8'h00);
        rd(2'd2, v); chk("R1 trig", v, 8'h00);
        chk("R1 int_out", {7'b0, int_out}, 8'h00);
        chk("R1 ack_vec", ack_vec, 8'h07);

        // R5 init sequence routes data writes
        init_std();
        rd(2'd1, v); chk("R5 mask untouched by init words", v, 8'h00);
        wr(2'd1, 8'hA5);
        rd(2'd1, v); chk("R5 mask after sequence", v, 8'hA5);
        wr(2'd1, 8'h00);

        // R3 / R7 edge sweep
        for (int i = 0; i < 8; i++) begin
            set_irq(8'(1 << i));
            set_irq(8'h00);
            rd(2'd0, v); chk("R3 edge held", v, 8'(1 << i));
            chk("R6 int_out", {7'b0, int_out}, 8'h01);
            do_ack(v); chk("R7 vector", v, 8'(8'h40 | i));
            rd(2'd0, v); chk("R7 edge irr cleared", v, 8'h00);
            rd_isr(v); chk("R7 isr set", v, 8'(1 << i));
            wr(2'd0, 8'h20);
            rd_isr(v); chk("R8 eoi clears", v, 8'h00);
        end

        // R2 / R4 / R11 per-line level sweep
        for (int i = 0; i < 8; i++) begin
            wr(2'd2, 8'(1 << i));
            rd(2'd2, v); chk("R11 trig readback", v, 8'(1 << i));
            set_irq(8'(1 << i));
            rd(2'd0, v); chk("R4 level set", v, 8'(1 << i));
            do_ack(v); chk("R7 level vector", v, 8'(8'h40 | i));
            rd(2'd0, v); chk("R7 level irr kept", v, 8'(1 << i));
            chk("R6 in service blocks", {7'b0, int_out}, 8'h00);
            wr(2'd0, 8'h20);
            chk("R2 level re-requests", {7'b0, int_out}, 8'h01);
            set_irq(8'h00);
            rd(2'd0, v); chk("R4 level cleared", v, 8'h00);
            wr(2'd2, 8'h00);
        end

        // R2 / R5 chip-wide level bit
        wr(2'd0, 8'h1B); wr(2'd1, 8'h40); wr(2'd1, 8'h01);
        set_irq(8'h20);
        rd(2'd0, v); chk("R2 chip-wide level set", v, 8'h20);
        do_ack(v); chk("R7 chip-wide vector", v, 8'h45);
        rd(2'd0, v); chk("R7 chip-wide irr kept", v, 8'h20);
        set_irq(8'h00);
        rd(2'd0, v); chk("R4 chip-wide follows low", v, 8'h00);
        rd(2'd2, v); chk("R11 trig unaffected", v, 8'h00);
        init_std();
        rd_isr(v); chk("R5 init clears isr", v, 8'h00);
        set_irq(8'h20); set_irq(8'h00);
        rd(2'd0, v); chk("R2 back to edge", v, 8'h20);
        do_ack(v); wr(2'd0, 8'h20);

        // R6 pair sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                set_irq(8'((1 << i) | (1 << j)));
                set_irq(8'h00);
                do_ack(v); chk("R6 pair first", v, 8'(8'h40 | i));
                wr(2'd0, 8'h20);
                do_ack(v); chk("R6 pair second", v, 8'(8'h40 | j));
                wr(2'd0, 8'h20);
            end
        end

        // R6 nesting
        set_irq(8'h10); set_irq(8'h00);
        do_ack(v); chk("R6 nest ack", v, 8'h44);
        set_irq(8'h40); set_irq(8'h00);
        chk("R6 lower blocked", {7'b0, int_out}, 8'h00);
        set_irq(8'h04); set_irq(8'h00);
        chk("R6 higher preempts", {7'b0, int_out}, 8'h01);
        do_ack(v); chk("R6 nested vector", v, 8'h42);
        rd_isr(v); chk("R8 two in service", v, 8'h14);
        wr(2'd0, 8'h20);
        rd_isr(v); chk("R8 highest cleared", v, 8'h10);
        wr(2'd0, 8'h20);
        rd_isr(v); chk("R8 second cleared", v, 8'h00);
        do_ack(v); chk("R6 pending low line", v, 8'h46);
        wr(2'd0, 8'h20);

        // R12 masking
        wr(2'd1, 8'h08);
        set_irq(8'h08); set_irq(8'h00);
        rd(2'd0, v); chk("R12 irr recorded", v, 8'h08);
        chk("R12 int_out low", {7'b0, int_out}, 8'h00);
        wr(2'd1, 8'h00);
        chk("R12 unmasked", {7'b0, int_out}, 8'h01);
        do_ack(v); wr(2'd0, 8'h20);

        // R7 spurious ack
        do_ack(v); chk("R7 spurious vector", v, 8'h47);
        rd_isr(v); chk("R7 spurious no isr", v, 8'h00);

        // R9 / R10 poll
        set_irq(8'h40); set_irq(8'h00);
        wr(2'd0, 8'h0C);
        poll_rd(v); chk("R10 poll word", v, 8'h86);
        rd_isr(v); chk("R10 poll acks", v, 8'h40);
        wr(2'd0, 8'h20);
        wr(2'd0, 8'h0C);
        poll_rd(v); chk("R10 empty poll", v, 8'h00);
        rd(2'd0, v); chk("R9 poll flag cleared", v, 8'h00);

        // R5 cascade sequence without fourth word
        wr(2'd0, 8'h10); wr(2'd1, 8'h48); wr(2'd1, 8'h04); wr(2'd1, 8'h3C);
        rd(2'd1, v); chk("R5 cascade mask", v, 8'h3C);
        wr(2'd1, 8'h00);
        set_irq(8'h04); set_irq(8'h00);
        do_ack(v); chk("R5 new base", v, 8'h4A);

        finish_run();
    end
endmodule